// File: doc/BRIEF.md
# 65C816 Bus Glue Address Decoder

This block is the glue logic for a small 65C816 computer fitted with 128KB of RAM, a boot ROM and seven I/O devices. During the low half of every bus cycle the processor puts its bank byte on the data bus. The block captures bit 0 of that byte and presents it as the extended address line A16 until the next low half.

From A16, address lines A15–A6 and the cycle-type signals, it drives one active-low select for RAM, one for ROM and one for each I/O device. It also drives qualified active-low read and write strobes. A wait request output tells an external clock generator to stretch ROM and I/O cycles.

A mode pin picks how finely the I/O window is carved. In page mode each device owns a 256-byte page starting at $00C000. In slot mode each device owns a 64-byte slot, so the window shrinks and the space it frees returns to RAM. All inputs are sampled on a fast system clock, and every output is a flip-flop.

Top module: `bus_glue_decoder`

## Requirements
- R1: `a16` takes the value of `bank_d0` one clock after any clock edge at which `phi2` is low. It keeps its value at every edge where `phi2` is high, so data on `bank_d0` during the high phase has no effect.
- R2: With `slot_mode`=0, a valid bank-0 access to $C000+n·$100 through $C0FF+n·$100 (n = 0..6) drives `io_cs_n[n]` low. The range $C700–$CFFF selects RAM.
- R3: With `slot_mode`=1, a valid bank-0 access to $C000+n·$40 through $C03F+n·$40 (n = 0..6) drives `io_cs_n[n]` low. The range $C1C0–$CFFF selects RAM.
- R4: A valid access to bank 0 below $C000, or to any address with A16=1, drives `ram_cs_n` low.
- R5: A valid read of bank 0 $D000–$FFFF drives `rom_cs_n` low. A write to that range drives no select.
- R6: `rd_n` is low only one clock after an edge that saw `phi2`=1, `rwb`=1 and a valid cycle. `wd_n` is low under the same conditions with `rwb`=0. Both strobes are high one clock after any edge that saw `phi2` low.
- R7: When `vda` and `vpa` are both low, no select and no strobe goes low.
- R8: `wse_n` is low exactly when the ROM select or an I/O select is low. It is high for RAM accesses and when nothing is selected.
- R9: Selects and `wse_n` follow the decoded inputs with one clock of latency. They decode against the registered `a16`.
- R10: At most one select output is low in any cycle.
- R11: While `rst` is high, every active-low output is driven high and `a16` is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled |
| rwb | input | 1 | Processor read (1) / write (0) |
| vda | input | 1 | Valid data address |
| vpa | input | 1 | Valid program address |
| addr_hi | input | 10 | Address lines A15..A6 |
| bank_d0 | input | 1 | Data bus bit 0, which carries the bank bit while phi2 is low |
| slot_mode | input | 1 | 0 = 256-byte I/O pages, 1 = 64-byte I/O slots |
| a16 | output | 1 | Latched extended address line |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 7 | Per-device I/O selects, active low |
| rd_n | output | 1 | Qualified read strobe, active low |
| wd_n | output | 1 | Qualified write strobe, active low |
| wse_n | output | 1 | Wait-state request to the clock generator, active low |

## Verification
Bank capture and address decode overlap: during the high phase the data bus carries unrelated data while the selects must still reflect the bank bit captured earlier. Each bench bus cycle therefore drives the inverted bank bit on `bank_d0` while `phi2` is high. It then checks that `a16`, the selects and `wse_n` are unchanged, and that the strobe for the cycle direction has gone low. Directed boundary addresses are run in both decode modes. Random cycles mix banks, directions and internal cycles, and each result is compared with a model function in the bench.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_ROM  = 2'd2,
    RGN_IO   = 2'd3
  } region_e;

  localparam int SLOT_IDX_W = 6;

  typedef struct packed {
    region_e               region;
    logic [SLOT_IDX_W-1:0] dev;
  } decode_t;
endpackage

// File: rtl/bg_bank_latch.sv
module bg_bank_latch (
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic bank_bit,
  output logic a16
);
  // Follow the bank bit through the whole low phase and freeze at the rise.
  always_ff @(posedge clk) begin
    if (rst)        a16 <= 1'b0;
    else if (!phi2) a16 <= bank_bit;
  end
endmodule

// File: rtl/bg_region_decode.sv
module bg_region_decode
  import bus_glue_pkg::*;
#(
  parameter int NUM_IO      = 7,
  parameter int IO_BASE_NIB = 12,
  parameter int ROM_BASE_NIB = 13
) (
  input  logic       a16,
  input  logic [9:0] addr_hi,   // A15..A6
  input  logic       rwb,
  input  logic       valid,
  input  logic       slot_mode,
  output decode_t    dec
);
  localparam logic [3:0]            IO_NIB  = 4'(IO_BASE_NIB);
  localparam logic [3:0]            ROM_NIB = 4'(ROM_BASE_NIB);
  localparam logic [SLOT_IDX_W-1:0] DEV_LIM = SLOT_IDX_W'(NUM_IO);

  logic [3:0]            top_nib;
  logic [SLOT_IDX_W-1:0] idx;

  assign top_nib = addr_hi[9:6];

  // Page index is A11..A8; slot index is A11..A6.
  always_comb begin
    if (slot_mode) idx = addr_hi[5:0];
    else           idx = {2'b00, addr_hi[5:2]};
  end

  always_comb begin
    dec.region = RGN_NONE;
    dec.dev    = '0;
    if (valid) begin
      if (a16 || (top_nib < IO_NIB)) begin
        dec.region = RGN_RAM;
      end else if (top_nib >= ROM_NIB) begin
        dec.region = rwb ? RGN_ROM : RGN_NONE;
      end else if (idx < DEV_LIM) begin
        dec.region = RGN_IO;
        dec.dev    = idx;
      end else begin
        dec.region = RGN_RAM;
      end
    end
  end
endmodule

// File: rtl/bg_select_reg.sv
module bg_select_reg
  import bus_glue_pkg::*;
#(
  parameter int NUM_IO = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  decode_t           dec,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic [NUM_IO-1:0] io_cs_n,
  output logic              wse_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs_n <= 1'b1;
      rom_cs_n <= 1'b1;
      wse_n    <= 1'b1;
    end else begin
      ram_cs_n <= (dec.region != RGN_RAM);
      rom_cs_n <= (dec.region != RGN_ROM);
      wse_n    <= !((dec.region == RGN_ROM) || (dec.region == RGN_IO));
    end
  end

  for (genvar g = 0; g < NUM_IO; g++) begin : g_io_sel
    always_ff @(posedge clk) begin
      if (rst) io_cs_n[g] <= 1'b1;
      else     io_cs_n[g] <= !((dec.region == RGN_IO) &&
                              (dec.dev == SLOT_IDX_W'(g)));
    end
  end
endmodule

// File: rtl/bg_strobe_gen.sv
module bg_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic rwb,
  input  logic valid,
  output logic rd_n,
  output logic wd_n
);
  logic qual;
  assign qual = phi2 && valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n <= 1'b1;
      wd_n <= 1'b1;
    end else begin
      rd_n <= !(qual && rwb);
      wd_n <= !(qual && !rwb);
    end
  end
endmodule

// File: rtl/bus_glue_decoder.sv
module bus_glue_decoder
  import bus_glue_pkg::*;
#(
  parameter int NUM_IO = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic              rwb,
  input  logic              vda,
  input  logic              vpa,
  input  logic [9:0]        addr_hi,
  input  logic              bank_d0,
  input  logic              slot_mode,
  output logic              a16,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic [NUM_IO-1:0] io_cs_n,
  output logic              rd_n,
  output logic              wd_n,
  output logic              wse_n
);
  logic    valid;
  decode_t dec;

  assign valid = vda || vpa;

  bg_bank_latch u_bank (
    .clk(clk), .rst(rst), .phi2(phi2), .bank_bit(bank_d0), .a16(a16)
  );

  bg_region_decode #(.NUM_IO(NUM_IO)) u_dec (
    .a16(a16), .addr_hi(addr_hi), .rwb(rwb), .valid(valid),
    .slot_mode(slot_mode), .dec(dec)
  );

  bg_select_reg #(.NUM_IO(NUM_IO)) u_sel (
    .clk(clk), .rst(rst), .dec(dec), .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .wse_n(wse_n)
  );

  bg_strobe_gen u_strb (
    .clk(clk), .rst(rst), .phi2(phi2), .rwb(rwb), .valid(valid),
    .rd_n(rd_n), .wd_n(wd_n)
  );
endmodule

// File: rtl/bus_glue_checker.sv
module bus_glue_checker #(
  parameter int NUM_IO = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2,
  input logic              rwb,
  input logic              vda,
  input logic              vpa,
  input logic              a16,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic [NUM_IO-1:0] io_cs_n,
  input logic              rd_n,
  input logic              wd_n,
  input logic              wse_n
);
  logic [NUM_IO+1:0] sel_act;
  assign sel_act = {~ram_cs_n, ~rom_cs_n, ~io_cs_n};

  assert_bank_hold_R1: assert property (@(posedge clk) disable iff (rst)
    $past(phi2) |-> $stable(a16));

  assert_rom_read_only_R5: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> $past(rwb));

  assert_strobe_low_phase_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(phi2) |-> (rd_n && wd_n));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wd_n));

  assert_internal_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(vda || vpa) |-> (sel_act == '0 && rd_n && wd_n));

  assert_wait_match_R8: assert property (@(posedge clk) disable iff (rst)
    (!wse_n) == (!rom_cs_n || (io_cs_n != '1)));

  assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_act));
endmodule

bind bus_glue_decoder bus_glue_checker #(.NUM_IO(NUM_IO)) u_chk (
  .clk(clk), .rst(rst), .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa),
  .a16(a16), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
  .rd_n(rd_n), .wd_n(wd_n), .wse_n(wse_n)
);

// File: tb/bus_glue_decoder_tb.sv
module bus_glue_decoder_tb;
  localparam int NIO = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2 = 1'b0, rwb = 1'b1, vda = 1'b0, vpa = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic bank_d0 = 1'b0, slot_mode = 1'b0;
  logic a16, ram_cs_n, rom_cs_n, rd_n, wd_n, wse_n;
  logic [NIO-1:0] io_cs_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_glue_decoder #(.NUM_IO(NIO)) u_dut (
    .clk(clk), .rst(rst), .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa),
    .addr_hi(addr[15:6]), .bank_d0(bank_d0), .slot_mode(slot_mode),
    .a16(a16), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
    .rd_n(rd_n), .wd_n(wd_n), .wse_n(wse_n)
  );

  // Model: {ram, rom, io[6:0]} active high.
  function automatic logic [NIO+1:0] model_sel(logic bk, logic [15:0] a,
                                               logic rd, logic vld, logic fine);
    logic [NIO+1:0] s = '0;
    int idx;
    if (!vld) return s;
    if (bk || a < 16'hC000) s[NIO+1] = 1'b1;
    else if (a >= 16'hD000) s[NIO] = rd;
    else begin
      idx = fine ? int'(a[11:6]) : int'(a[11:8]);
      if (idx < NIO) s[idx] = 1'b1;
      else s[NIO+1] = 1'b1;
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sel_checks(string req, logic [NIO+1:0] e);
    logic [NIO+1:0] got;
    got = {~ram_cs_n, ~rom_cs_n, ~io_cs_n};
    check(got == e, req, "selects", int'(got), int'(e));
    check(wse_n == !(e[NIO] || (e[NIO-1:0] != '0)), "R8", "wse_n",
          int'(wse_n), int'(!(e[NIO] || (e[NIO-1:0] != '0))));
  endtask

  task automatic bus_cycle(logic bk, logic [15:0] a, logic rd, logic v_d,
                           logic v_p, logic fine, string req);
    logic [NIO+1:0] e;
    logic vld;
    vld = v_d | v_p;
    e = model_sel(bk, a, rd, vld, fine);
    @(negedge clk);
    phi2 = 1'b0; bank_d0 = bk; addr = a; rwb = rd;
    vda = v_d; vpa = v_p; slot_mode = fine;
    repeat (2) @(negedge clk);
    check(a16 == bk, "R1", "a16 low phase", int'(a16), int'(bk));
    sel_checks(req, e);
    check(rd_n && wd_n, "R6", "strobes in low phase", int'({rd_n, wd_n}), 3);
    // High phase: bus now carries data; the bank bit is flipped on purpose.
    phi2 = 1'b1; bank_d0 = ~bk;
    repeat (2) @(negedge clk);
    check(a16 == bk, "R1", "a16 high-phase hold", int'(a16), int'(bk));
    sel_checks("R9", e);
    check(rd_n == !(vld && rd), vld ? "R6" : "R7", "rd_n",
          int'(rd_n), int'(!(vld && rd)));
    check(wd_n == !(vld && !rd), vld ? "R6" : "R7", "wd_n",
          int'(wd_n), int'(!(vld && !rd)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; bank_d0 = 1'b1; phi2 = 1'b0; vda = 1'b1;
    repeat (3) @(negedge clk);
    check({ram_cs_n, rom_cs_n, io_cs_n, rd_n, wd_n, wse_n} == '1, "R11",
          "reset outputs", int'({ram_cs_n, rom_cs_n, io_cs_n, rd_n, wd_n, wse_n}),
          int'({(NIO+5){1'b1}}));
    check(a16 == 1'b0, "R11", "reset a16", int'(a16), 0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      logic fine;
      fine = logic'(m);
      bus_cycle(1'b0, 16'hBFFF, 1'b1, 1'b1, 1'b0, fine, "R4");
      bus_cycle(1'b0, 16'hC000, 1'b1, 1'b1, 1'b0, fine, fine ? "R3" : "R2");
      bus_cycle(1'b0, fine ? 16'hC1BF : 16'hC6FF, 1'b0, 1'b1, 1'b0, fine,
                fine ? "R3" : "R2");
      bus_cycle(1'b0, fine ? 16'hC1C0 : 16'hC700, 1'b1, 1'b1, 1'b0, fine,
                fine ? "R3" : "R2");
      bus_cycle(1'b0, 16'hCFFF, 1'b0, 1'b1, 1'b0, fine, fine ? "R3" : "R2");
      bus_cycle(1'b0, 16'hD000, 1'b1, 1'b0, 1'b1, fine, "R5");
      bus_cycle(1'b0, 16'hD000, 1'b0, 1'b1, 1'b0, fine, "R5");
      bus_cycle(1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, fine, "R4");
      bus_cycle(1'b1, 16'hC000, 1'b0, 1'b1, 1'b0, fine, "R4");
      bus_cycle(1'b0, 16'hC080, 1'b1, 1'b0, 1'b0, fine, "R7");
      for (int d = 0; d < NIO; d++)
        bus_cycle(1'b0, fine ? 16'hC000 + 16'(d * 64) + 16'h3F
                             : 16'hC000 + 16'(d * 256) + 16'hFF,
                  1'b1, 1'b1, 1'b0, fine, fine ? "R3" : "R2");
    end

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [31:0] r;
      r = $urandom;
      a = r[0] ? (16'hC000 | 16'($urandom_range(0, 16'h0FFF))) : 16'($urandom);
      bus_cycle(r[1], a, r[2], r[3] | r[5], r[4] | r[6], r[7], "R10");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule